// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block sits between a host that asks for a new PLL frequency and the control and divider register images that drive an analog PLL. A host request carries an operation code and a divider set (feedback multiplier m, pre-divider p, post-divider s and, for the fractional variant, a 16-bit fraction k). The sequencer then takes the PLL through a safe change. It asserts reset, sets bypass, loads the dividers and waits out a settling time. It then releases reset, waits a bounded time for lock, and finally drops bypass so the PLL output is used again.

Two shortcuts keep common requests cheap. If the requested m and p match the ones already loaded, only the post-divider (and the fraction) is rewritten, and the PLL keeps running without a relock. Power-up and power-down requests reuse the same reset, bypass and lock steps. If lock never arrives, the sequencer gives up after a fixed number of microseconds and raises an error. Bypass is left set, so logic downstream keeps running on the reference clock. Microsecond delays are derived from a ticks-per-microsecond parameter.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the control image, both divider images, `busy`, `done` and `errTimeout` are all zero. This means the PLL is held in reset (bit 9 low) with bypass off.
- R2: The control image carries the synchronised lock input at bit 31, lock-source select at bit 29, a clock enable at bit 11 (always 0), active-low PLL reset at bit 9 and bypass at bit 4. Divider image 0 holds m in bits 21:12, p in bits 9:4 and s in bits 2:0. Divider image 1 holds k in bits 15:0 in the fractional variant and stays zero in the integer variant.
- R3: A program request (code 0) whose m and p equal the loaded ones rewrites only s (and k when fractional). Reset and bypass stay unchanged, and `done` pulses two cycles after the request is taken.
- R4: A program request with a new m or p performs these steps in order: reset low, bypass high, divider load, a wait of at least SETTLE_US*TICKS_PER_US cycles, reset release, a lock wait, and bypass clear. Bypass is only cleared once lock has been seen.
- R5: In the integer variant, the lock-source select bit is set at the start of a full reprogram and stays set.
- R6: If lock does not appear within TIMEOUT_US*TICKS_PER_US cycles of reset release, `errTimeout` rises, `busy` falls, `done` stays low and bypass stays set.
- R7: A prepare request (code 1) completes at once when reset is already released. Otherwise it sets bypass, releases reset, waits for lock and clears bypass.
- R8: An unprepare request (code 2) drives the reset bit low and completes with `done`.
- R9: `busy` is high from the cycle after a request is taken until completion. A request presented while `busy` is high, or one with code 3, is ignored and changes no image.
- R10: `done` is a one-cycle pulse that coincides with `busy` falling. `errTimeout` stays set until the next accepted request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 2 | 0 program, 1 prepare, 2 unprepare, 3 ignored |
| reqM | input | 10 | Requested feedback multiplier |
| reqP | input | 6 | Requested pre-divider |
| reqS | input | 3 | Requested post-divider |
| reqK | input | 16 | Requested fraction (fractional variant) |
| pllLock | input | 1 | Lock indication from the PLL |
| ctlWord | output | 32 | Control register image |
| divWord0 | output | 32 | Divider image holding m, p and s |
| divWord1 | output | 32 | Divider image holding k |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| errTimeout | output | 1 | Lock wait expired |

## Verification
Two events can fall in the same cycle: a completion (`done` high, `busy` just low) and the arrival of the next request. The bench provokes this by raising `reqValid` on the very cycle it observes `done`. It then judges that the new request is taken: `busy` is high one cycle later, and the new post-divider appears in the image. A second overlap is a request arriving mid-sequence, which must leave the divider image with the first request's values. A third is the cycle in which the lock wait runs out: at that point the bench checks that the error and the retained bypass appear together, with no `done`.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROGRAM   = 2'd0,
    OP_PREPARE   = 2'd1,
    OP_UNPREPARE = 2'd2,
    OP_NONE      = 2'd3
  } op_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic accept;
    logic lockSel;
    logic rstLow;
    logic rstHigh;
    logic bypSet;
    logic bypClr;
    logic loadFull;
    logic loadFast;
    logic startSettle;
    logic startTimeout;
    logic doneSet;
    logic errSet;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic mpMatch;
    logic rstReleased;
    logic timerZero;
    logic lockSync;
  } status_t;

endpackage

// File: rtl/pll_seq_dp.sv
module pll_seq_dp
  import pll_seq_pkg::*;
#(
  parameter int FRACTIONAL   = 0,
  parameter int TICKS_PER_US = 100,
  parameter int SETTLE_US    = 3,
  parameter int TIMEOUT_US   = 10000,
  parameter int M_W          = 10,
  parameter int P_W          = 6,
  parameter int S_W          = 3,
  parameter int K_W          = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        stb,
  input  logic [M_W-1:0] reqM,
  input  logic [P_W-1:0] reqP,
  input  logic [S_W-1:0] reqS,
  input  logic [K_W-1:0] reqK,
  input  logic           pllLock,
  output status_t        stat,
  output logic [31:0]    ctlWord,
  output logic [31:0]    divWord0,
  output logic [31:0]    divWord1,
  output logic           done,
  output logic           errTimeout
);

  localparam int SETTLE_CYC  = SETTLE_US * TICKS_PER_US;
  localparam int TIMEOUT_CYC = TIMEOUT_US * TICKS_PER_US;
  localparam int MAX_CYC     = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC;
  localparam int CNT_W       = $clog2(MAX_CYC + 1);

  logic [M_W-1:0] pendM, curM;
  logic [P_W-1:0] pendP, curP;
  logic [S_W-1:0] pendS, curS;
  logic [K_W-1:0] pendK, curK;
  logic           lockSelQ, rstBitQ, bypQ;
  logic           lockMeta, lockSyncQ;
  logic [CNT_W-1:0] timer;

  // pending request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendM <= '0; pendP <= '0; pendS <= '0; pendK <= '0;
    end else if (stb.accept) begin
      pendM <= reqM; pendP <= reqP; pendS <= reqS; pendK <= reqK;
    end
  end

  // divider images
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curM <= '0; curP <= '0; curS <= '0; curK <= '0;
    end else begin
      if (stb.loadFull) begin
        curM <= pendM;
        curP <= pendP;
      end
      if (stb.loadFull || stb.loadFast) begin
        curS <= pendS;
        if (FRACTIONAL != 0) curK <= pendK;
      end
    end
  end

  // control bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockSelQ <= 1'b0; rstBitQ <= 1'b0; bypQ <= 1'b0;
    end else begin
      if (stb.lockSel) lockSelQ <= 1'b1;
      if (stb.rstLow)       rstBitQ <= 1'b0;
      else if (stb.rstHigh) rstBitQ <= 1'b1;
      if (stb.bypSet)       bypQ <= 1'b1;
      else if (stb.bypClr)  bypQ <= 1'b0;
    end
  end

  // lock synchroniser
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockMeta <= 1'b0; lockSyncQ <= 1'b0;
    end else begin
      lockMeta <= pllLock; lockSyncQ <= lockMeta;
    end
  end

  // shared microsecond-derived down counter
  always_ff @(posedge clk) begin
    if (!rstN)                 timer <= '0;
    else if (stb.startSettle)  timer <= CNT_W'(SETTLE_CYC - 1);
    else if (stb.startTimeout) timer <= CNT_W'(TIMEOUT_CYC - 1);
    else if (timer != '0)      timer <= timer - 1'b1;
  end

  // completion flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0; errTimeout <= 1'b0;
    end else begin
      done <= stb.doneSet;
      if (stb.errSet)      errTimeout <= 1'b1;
      else if (stb.accept) errTimeout <= 1'b0;
    end
  end

  always_comb begin
    ctlWord     = '0;
    ctlWord[31] = lockSyncQ;
    ctlWord[29] = lockSelQ;
    ctlWord[11] = 1'b0;
    ctlWord[9]  = rstBitQ;
    ctlWord[4]  = bypQ;
  end

  assign divWord0 = {{(32-22){1'b0}}, curM, 2'b00, curP, 1'b0, curS};
  assign divWord1 = {{(32-K_W){1'b0}}, curK};

  assign stat.mpMatch     = (pendM == curM) && (pendP == curP);
  assign stat.rstReleased = rstBitQ;
  assign stat.timerZero   = (timer == '0);
  assign stat.lockSync    = lockSyncQ;

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int FRACTIONAL = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  status_t    stat,
  output strobe_t    stb,
  output logic       busy
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_RST, ST_BYP, ST_DIV, ST_SETTLE,
    ST_PCHK, ST_REL, ST_LOCK, ST_UNBYP, ST_DOWN
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid && (op_e'(reqOp) != OP_NONE)) begin
          stb.accept = 1'b1;
          case (op_e'(reqOp))
            OP_PROGRAM: stateNext = ST_CHECK;
            OP_PREPARE: stateNext = ST_PCHK;
            default:    stateNext = ST_DOWN;
          endcase
        end
      end
      ST_CHECK: begin
        if (stat.mpMatch) begin
          stb.loadFast = 1'b1;
          stb.doneSet  = 1'b1;
          stateNext    = ST_IDLE;
        end else if (FRACTIONAL == 0) begin
          stb.lockSel = 1'b1;
          stateNext   = ST_RST;
        end else begin
          stb.rstLow = 1'b1;
          stateNext  = ST_BYP;
        end
      end
      ST_RST: begin
        stb.rstLow = 1'b1;
        stateNext  = ST_BYP;
      end
      ST_BYP: begin
        stb.bypSet = 1'b1;
        stateNext  = ST_DIV;
      end
      ST_DIV: begin
        stb.loadFull    = 1'b1;
        stb.startSettle = 1'b1;
        stateNext       = ST_SETTLE;
      end
      ST_SETTLE: if (stat.timerZero) stateNext = ST_REL;
      ST_PCHK: begin
        if (stat.rstReleased) begin
          stb.doneSet = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          stb.bypSet = 1'b1;
          stateNext  = ST_REL;
        end
      end
      ST_REL: begin
        stb.rstHigh      = 1'b1;
        stb.startTimeout = 1'b1;
        stateNext        = ST_LOCK;
      end
      ST_LOCK: begin
        if (stat.lockSync) stateNext = ST_UNBYP;
        else if (stat.timerZero) begin
          stb.errSet = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      ST_UNBYP: begin
        stb.bypClr  = 1'b1;
        stb.doneSet = 1'b1;
        stateNext   = ST_IDLE;
      end
      ST_DOWN: begin
        stb.rstLow  = 1'b1;
        stb.doneSet = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int FRACTIONAL   = 0,
  parameter int TICKS_PER_US = 100,
  parameter int SETTLE_US    = 3,
  parameter int TIMEOUT_US   = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [9:0]  reqM,
  input  logic [5:0]  reqP,
  input  logic [2:0]  reqS,
  input  logic [15:0] reqK,
  input  logic        pllLock,
  output logic [31:0] ctlWord,
  output logic [31:0] divWord0,
  output logic [31:0] divWord1,
  output logic        busy,
  output logic        done,
  output logic        errTimeout
);

  strobe_t stb;
  status_t stat;

  pll_seq_ctrl #(.FRACTIONAL(FRACTIONAL)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .stat(stat), .stb(stb), .busy(busy)
  );

  pll_seq_dp #(
    .FRACTIONAL(FRACTIONAL), .TICKS_PER_US(TICKS_PER_US),
    .SETTLE_US(SETTLE_US), .TIMEOUT_US(TIMEOUT_US),
    .M_W(10), .P_W(6), .S_W(3), .K_W(16)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqM(reqM), .reqP(reqP), .reqS(reqS), .reqK(reqK),
    .pllLock(pllLock), .stat(stat),
    .ctlWord(ctlWord), .divWord0(divWord0), .divWord1(divWord1),
    .done(done), .errTimeout(errTimeout)
  );

endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic        errTimeout,
  input logic [31:0] ctlWord,
  input logic [31:0] divWord0
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R10

  AST_ERR_KEEPS_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errTimeout) |-> (ctlWord[4] && !done)); // R6

  AST_UNBYPASS_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlWord[4]) |-> ($past(ctlWord[31]) && ctlWord[9])); // R4

  AST_BYPASS_UNDER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlWord[4]) |-> !ctlWord[9]); // R4

  AST_DIV_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divWord0) |-> $past(busy)); // R9

endmodule

bind pll_reprog_seq pll_reprog_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .errTimeout(errTimeout), .ctlWord(ctlWord), .divWord0(divWord0)
);

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;

  localparam int TICKS       = 2;
  localparam int SETTLE_CYC  = 3 * TICKS;
  localparam int TIMEOUT_CYC = 10000 * TICKS;
  localparam int LOCK_DLY    = 10;

  typedef struct packed {
    logic [1:0]  op;
    logic [9:0]  m;
    logic [5:0]  p;
    logic [2:0]  s;
    logic [15:0] k;
    logic        full;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 10'd200, 6'd3, 3'd0, 16'd0,   1'b1},
    '{2'd0, 10'd200, 6'd3, 3'd1, 16'd100, 1'b0},
    '{2'd0, 10'd250, 6'd2, 3'd2, 16'd0,   1'b1},
    '{2'd0, 10'd250, 6'd2, 3'd3, 16'd7,   1'b0},
    '{2'd2, 10'd0,   6'd0, 3'd0, 16'd0,   1'b0},
    '{2'd1, 10'd0,   6'd0, 3'd0, 16'd0,   1'b1},
    '{2'd1, 10'd0,   6'd0, 3'd0, 16'd0,   1'b0},
    '{2'd0, 10'd250, 6'd3, 3'd3, 16'd0,   1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = '0;
  logic [9:0] reqM = '0;
  logic [5:0] reqP = '0;
  logic [2:0] reqS = '0;
  logic [15:0] reqK = '0;
  logic pllLock = 1'b0;
  logic lockEn = 1'b1;
  int lockCnt = 0;
  logic [31:0] ctlWord, divWord0, divWord1;
  logic busy, done, errTimeout;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tBypSet, tBypClr, tDivWr, tRstRel, tLock, tErr;
  logic [31:0] prevCtl = '0, prevDiv = '0;
  logic prevErr = 1'b0;
  int waitCnt;
  logic [9:0] expM;
  logic [5:0] expP;
  logic [2:0] expS;
  logic expRst;

  always #5 clk = ~clk;

  pll_reprog_seq #(.FRACTIONAL(0), .TICKS_PER_US(TICKS), .SETTLE_US(3), .TIMEOUT_US(10000)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqM(reqM), .reqP(reqP), .reqS(reqS), .reqK(reqK), .pllLock(pllLock),
    .ctlWord(ctlWord), .divWord0(divWord0), .divWord1(divWord1),
    .busy(busy), .done(done), .errTimeout(errTimeout)
  );

  // PLL model: lock some cycles after reset release
  always @(posedge clk) begin
    if (!ctlWord[9] || !lockEn) begin
      lockCnt <= 0;
      pllLock <= 1'b0;
    end else begin
      if (lockCnt < LOCK_DLY) lockCnt <= lockCnt + 1;
      pllLock <= (lockCnt >= LOCK_DLY);
    end
  end

  // event monitor and watchdog
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (!prevCtl[4] && ctlWord[4]) tBypSet <= cyc + 1;
      if (prevCtl[4] && !ctlWord[4]) tBypClr <= cyc + 1;
      if (!prevCtl[9] && ctlWord[9]) tRstRel <= cyc + 1;
      if (!prevCtl[31] && ctlWord[31]) tLock <= cyc + 1;
      if (prevDiv != divWord0) tDivWr <= cyc + 1;
      if (!prevErr && errTimeout) tErr <= cyc + 1;
    end
    prevCtl <= ctlWord;
    prevDiv <= divWord0;
    prevErr <= errTimeout;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearStamps();
    tBypSet = 0; tBypClr = 0; tDivWr = 0; tRstRel = 0; tLock = 0; tErr = 0;
  endtask

  task automatic drive(input logic [1:0] op, input logic [9:0] m, input logic [5:0] p,
                       input logic [2:0] s, input logic [15:0] k);
    reqValid = 1'b1; reqOp = op; reqM = m; reqP = p; reqS = s; reqK = k;
  endtask

  task automatic send(input logic [1:0] op, input logic [9:0] m, input logic [5:0] p,
                      input logic [2:0] s, input logic [15:0] k);
    @(negedge clk);
    drive(op, m, p, s, k);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(input int limit);
    waitCnt = 0;
    while (!done && !errTimeout && waitCnt < limit) begin
      @(negedge clk);
      waitCnt++;
    end
    #1;
  endtask

  initial begin
    clearStamps();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ctlWord", ctlWord, 32'h0);
    chk("R1 divWord0", divWord0, 32'h0);
    chk("R1 divWord1", divWord1, 32'h0);
    chk("R1 busy/done/err", {29'b0, busy, done, errTimeout}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {ctlWord[29], ctlWord[9], ctlWord[4], busy}, 32'h0);

    expM = '0; expP = '0; expS = '0; expRst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      clearStamps();
      send(VECS[i].op, VECS[i].m, VECS[i].p, VECS[i].s, VECS[i].k);
      chk("R9 busy after accept", {31'b0, busy}, 32'd1);
      waitDone(2000);
      chk("R10 done seen", {30'b0, done, errTimeout}, 32'd2);
      chk("R10 busy low with done", {31'b0, busy}, 32'd0);
      if (VECS[i].op == 2'd0) begin
        expM = VECS[i].m; expP = VECS[i].p; expS = VECS[i].s; expRst = 1'b1;
      end else if (VECS[i].op == 2'd1) expRst = 1'b1;
      else expRst = 1'b0;
      chk("R2 divider image m/p/s", divWord0,
          {10'b0, expM, 2'b0, expP, 1'b0, expS});
      chk("R2 integer k image zero", divWord1, 32'h0);
      chk("R8 R7 reset bit", {31'b0, ctlWord[9]}, {31'b0, expRst});
      chk("R4 bypass cleared", {31'b0, ctlWord[4]}, 32'd0);
      if (!VECS[i].full) begin
        chk("R3 quick completion", (waitCnt <= 2) ? 32'd1 : 32'd0, 32'd1);
        chk("R3 reset/bypass untouched", {tRstRel == 0, tBypSet == 0}, 32'd3);
      end else begin
        chk("R4 full order byp<div<rel<unbyp",
            ((VECS[i].op == 2'd1 || tBypSet < tDivWr) && tBypSet > 0 &&
             tBypSet < tRstRel && tRstRel < tBypClr) ? 32'd1 : 32'd0, 32'd1);
        if (VECS[i].op == 2'd0)
          chk("R4 settle gap", (tRstRel - tDivWr >= SETTLE_CYC) ? 32'd1 : 32'd0, 32'd1);
        chk("R4 lock before unbypass", (tLock > 0 && tLock < tBypClr) ? 32'd1 : 32'd0, 32'd1);
        chk("R2 lock status mirrored", {31'b0, ctlWord[31]}, 32'd1);
      end
      if (i == 0) chk("R5 lock-source select set", {31'b0, ctlWord[29]}, 32'd1);
    end

    // R9: request during busy is ignored
    send(2'd0, 10'd300, 6'd4, 3'd1, 16'd0);
    repeat (2) @(negedge clk);
    chk("R9 busy when second request shown", {31'b0, busy}, 32'd1);
    drive(2'd0, 10'd100, 6'd1, 3'd2, 16'd0);
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(2000);
    chk("R9 ignored request left no trace", divWord0, {10'b0, 10'd300, 2'b0, 6'd4, 1'b0, 3'd1});
    repeat (3) @(negedge clk);
    chk("R9 no second sequence", {31'b0, busy}, 32'd0);

    // R9: reserved op code ignored
    send(2'd3, 10'd5, 6'd5, 3'd5, 16'd0);
    chk("R9 code 3 not accepted", {31'b0, busy}, 32'd0);
    chk("R9 code 3 image unchanged", divWord0, {10'b0, 10'd300, 2'b0, 6'd4, 1'b0, 3'd1});

    // R10: request on the completion cycle is accepted
    send(2'd0, 10'd300, 6'd4, 3'd4, 16'd0);
    waitCnt = 0;
    while (!done && waitCnt < 20) begin @(negedge clk); waitCnt++; end
    drive(2'd0, 10'd300, 6'd4, 3'd6, 16'd0);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10 back-to-back request taken", {31'b0, busy}, 32'd1);
    waitDone(20);
    chk("R3 back-to-back post-divider", {29'b0, divWord0[2:0]}, 32'd6);

    // R6: lock never arrives
    lockEn = 1'b0;
    repeat (4) @(negedge clk);
    clearStamps();
    send(2'd0, 10'd320, 6'd3, 3'd0, 16'd0);
    waitDone(TIMEOUT_CYC + 200);
    chk("R6 error raised without done", {30'b0, errTimeout, done}, 32'd2);
    chk("R6 bypass kept, reset released", {30'b0, ctlWord[4], ctlWord[9]}, 32'd3);
    chk("R6 busy dropped", {31'b0, busy}, 32'd0);
    chk("R6 timeout window", (tErr - tRstRel >= TIMEOUT_CYC && tErr - tRstRel <= TIMEOUT_CYC + 2)
        ? 32'd1 : 32'd0, 32'd1);
    repeat (3) @(negedge clk);
    chk("R10 error held", {31'b0, errTimeout}, 32'd1);

    // R10: error cleared by next accepted request (fast path keeps bypass, R3)
    lockEn = 1'b1;
    send(2'd0, 10'd320, 6'd3, 3'd2, 16'd0);
    waitDone(20);
    chk("R10 error cleared", {31'b0, errTimeout}, 32'd0);
    chk("R3 fast path leaves bypass", {31'b0, ctlWord[4]}, 32'd1);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule